// File: doc/BRIEF.md
# Glitch-Free Two-Input Clock Selector

This block chooses which of two free-running, unrelated clocks drives a single clock output. Moving from one source to the other never produces a runt pulse: the outgoing clock keeps driving until its next active transition, then the output rests at a fixed idle level. The incoming clock takes over only after it has made an active transition of its own. A static parameter sets the polarity. Either the handover happens on falling edges with the output resting low, or on rising edges with the output resting high.

Each source is requested through a pair of lines, a select and an enable, and is requested only while both are high. Normally one line of each pair is the real selector and the other is tied high. The select lines may change at any time, because they are synchronised into each clock domain. The enable lines are sampled directly, so they must meet setup and hold in both domains. Each source also has a bypass line. While it is high, the output drops that source at the moment its request falls, without waiting for the safe edge. Two static parameters name the source that owns the output when reset is applied. A status output reports that exactly one source owns the output.

Top module: `clk_sel2`

## Requirements
- R1: A source is requested only while its select line and its enable line are both high. A source whose enable is low is never chosen, whatever its select line holds.
- R2: When the request moves from the owning source to the other one, the output keeps following the old clock until that clock's active transition. It then rests at the idle level, and the new clock drives it only after the new clock's active transition. No high or low phase shorter than the shorter input half-period ever appears.
- R3: With `IDLE_HIGH` = 0 the active transition is high-to-low and the resting level is 0. With `IDLE_HIGH` = 1 the active transition is low-to-high and the resting level is 1.
- R4: While `bypass_a` (or `bypass_b`) is high, the output stops following that source at the instant its request falls, even if that clock is high at that moment.
- R5: During and right after reset, the source whose parameter `INIT_OWN_A` / `INIT_OWN_B` is 1 owns the output and `settled` is 1.
- R6: While both sources are requested at once, the current owner keeps the output. If no source owned it, the output stays at rest.
- R7: While neither source is requested, the output rests at the idle level after the owning clock's active transition, and it makes no edges.
- R8: `settled` is 1 exactly when one source owns the output, and 0 while the output is resting.
- R9: The two sources never own the output at the same time. A source takes ownership only after it has seen, through its synchroniser, that the other source released it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Source clock A (source 0) |
| clk_b | input | 1 | Source clock B (source 1) |
| rst_n | input | 1 | Active-low reset, sampled on each domain's active edge |
| sel_a | input | 1 | Select line of source A, may be asynchronous |
| en_a | input | 1 | Enable line of source A, must meet setup/hold in both domains |
| sel_b | input | 1 | Select line of source B, may be asynchronous |
| en_b | input | 1 | Enable line of source B, must meet setup/hold in both domains |
| bypass_a | input | 1 | Drop source A immediately when its request falls |
| bypass_b | input | 1 | Drop source B immediately when its request falls |
| clk_out | output | 1 | Selected clock, or the idle level while switching |
| settled | output | 1 | High when exactly one source owns the output |

## Verification
A wrong ownership flag shows up at `clk_out` within one period of the slower clock. It appears as a period that matches the wrong source, as edges while the output should be resting, or as a high or low phase shorter than either half-period. A broken handshake or synchroniser shows up as a runt pulse during a switch, or as `settled` not reaching the expected value within a few cycles of each clock. A bypass fault is visible within a fraction of a nanosecond, because the output must fall while the old clock is still high.

// File: rtl/clk_sel_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the two-source clock selector.
// Assumes exactly two sources; index 0 is source A, index 1 is source B.
package clk_sel_pkg;
    localparam int NUM_SRC = 2;
    typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/clk_sel_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser for a single asynchronous level.
// Assumes STAGES >= 2 and a synchronous active-low reset on the capture clock.
module clk_sel_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[LAST-1:0], d};
    end

    assign q = chain_q[LAST];
endmodule

// File: rtl/clk_sel_lane.sv
`timescale 1ns/1ps
// One source lane: holds the "owns output" flag of its clock.
// All flops run on the active edge of the lane's clock (falling when the
// output rests low, rising when it rests high). Select lines and the other
// lane's flag arrive through synchronisers; enables are sampled directly and
// must meet setup and hold in this domain.
module clk_sel_lane #(
    parameter bit IDLE_HIGH   = 1'b0,
    parameter bit INIT_MINE   = 1'b0,
    parameter bit INIT_OTHER  = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_mine,
    input  logic en_mine,
    input  logic sel_other,
    input  logic en_other,
    input  logic other_own,
    output logic own_q
);
    logic act_clk;
    logic sel_mine_s;
    logic sel_other_s;
    logic other_own_s;
    logic req_mine;
    logic req_other;
    logic grab;

    // Pick the active edge from the idle polarity.
    generate
        if (IDLE_HIGH) begin : g_rise
            assign act_clk = clk;
        end else begin : g_fall
            assign act_clk = ~clk;
        end
    endgenerate

    clk_sel_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(INIT_MINE)) u_sync_sel_mine (
        .clk(act_clk), .rst_n(rst_n), .d(sel_mine), .q(sel_mine_s)
    );
    clk_sel_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(INIT_OTHER)) u_sync_sel_other (
        .clk(act_clk), .rst_n(rst_n), .d(sel_other), .q(sel_other_s)
    );
    clk_sel_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(INIT_OTHER)) u_sync_own (
        .clk(act_clk), .rst_n(rst_n), .d(other_own), .q(other_own_s)
    );

    // Request decode and takeover condition.
    always_comb begin
        req_mine  = sel_mine_s & en_mine;
        req_other = sel_other_s & en_other;
        grab      = req_mine & ~req_other & ~other_own_s;
    end

    // Ownership flag: keep while requested, take only when the other is clear.
    always_ff @(posedge act_clk) begin
        if (!rst_n)     own_q <= INIT_MINE;
        else if (own_q) own_q <= req_mine;
        else            own_q <= grab;
    end
endmodule

// File: rtl/clk_sel_gate.sv
`timescale 1ns/1ps
// Output combiner: passes each owning clock and holds the idle level otherwise.
// Assumes pass flags only change while their clock sits at the idle level,
// except for an intended bypass cut.
module clk_sel_gate
    import clk_sel_pkg::*;
#(
    parameter bit IDLE_HIGH = 1'b0
) (
    input  src_vec_t clk_vec,
    input  src_vec_t pass_vec,
    output logic     clk_out
);
    generate
        if (IDLE_HIGH) begin : g_high
            // Rest high: AND of clocks forced high when not passed.
            always_comb begin
                clk_out = 1'b1;
                for (int i = 0; i < NUM_SRC; i++) clk_out = clk_out & (clk_vec[i] | ~pass_vec[i]);
            end
        end else begin : g_low
            // Rest low: OR of clocks gated by their pass flags.
            always_comb begin
                clk_out = 1'b0;
                for (int i = 0; i < NUM_SRC; i++) clk_out = clk_out | (clk_vec[i] & pass_vec[i]);
            end
        end
    endgenerate
endmodule

// File: rtl/clk_sel2.sv
`timescale 1ns/1ps
// Glitch-free two-source clock selector.
// Assumes: at most one ownership preset is set; rst_n is held low for several
// active edges of both clocks; selection changes are spaced by the settling
// time; enables meet setup and hold in both clock domains.
module clk_sel2
    import clk_sel_pkg::*;
#(
    parameter bit IDLE_HIGH   = 1'b0,
    parameter bit INIT_OWN_A  = 1'b1,
    parameter bit INIT_OWN_B  = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst_n,
    input  logic sel_a,
    input  logic en_a,
    input  logic sel_b,
    input  logic en_b,
    input  logic bypass_a,
    input  logic bypass_b,
    output logic clk_out,
    output logic settled
);
    localparam src_vec_t INIT_VEC = {INIT_OWN_B, INIT_OWN_A};

    src_vec_t clk_vec;
    src_vec_t sel_vec;
    src_vec_t en_vec;
    src_vec_t byp_vec;
    src_vec_t own_q;
    src_vec_t pass_vec;

    assign clk_vec = {clk_b, clk_a};
    assign sel_vec = {sel_b, sel_a};
    assign en_vec  = {en_b, en_a};
    assign byp_vec = {bypass_b, bypass_a};

    // One lane per source, each watching the other lane's flag.
    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
            localparam int OTHER = NUM_SRC - 1 - i;

            clk_sel_lane #(
                .IDLE_HIGH  (IDLE_HIGH),
                .INIT_MINE  (INIT_VEC[i]),
                .INIT_OTHER (INIT_VEC[OTHER]),
                .SYNC_STAGES(SYNC_STAGES)
            ) u_lane (
                .clk      (clk_vec[i]),
                .rst_n    (rst_n),
                .sel_mine (sel_vec[i]),
                .en_mine  (en_vec[i]),
                .sel_other(sel_vec[OTHER]),
                .en_other (en_vec[OTHER]),
                .other_own(own_q[OTHER]),
                .own_q    (own_q[i])
            );

            // Bypass cuts the lane as soon as its raw request falls.
            assign pass_vec[i] = own_q[i] & ~(byp_vec[i] & ~(sel_vec[i] & en_vec[i]));
        end
    endgenerate

    clk_sel_gate #(.IDLE_HIGH(IDLE_HIGH)) u_gate (
        .clk_vec (clk_vec),
        .pass_vec(pass_vec),
        .clk_out (clk_out)
    );

    // Handover complete when exactly one lane owns the output.
    assign settled = $onehot(own_q);
endmodule

// File: rtl/clk_sel2_chk.sv
`timescale 1ns/1ps
// Assertion checker for clk_sel2, attached with bind below.
// Samples on both source clocks; all properties are off during reset.
module clk_sel2_chk
    import clk_sel_pkg::*;
#(
    parameter bit IDLE_HIGH = 1'b0
) (
    input logic     clk_a,
    input logic     clk_b,
    input logic     rst_n,
    input logic     sel_a,
    input logic     en_a,
    input logic     sel_b,
    input logic     en_b,
    input logic     bypass_a,
    input logic     bypass_b,
    input logic     clk_out,
    input logic     settled,
    input src_vec_t own_q
);
    // R9: never two owners.
    p_single_owner_r9: assert property (@(posedge clk_a) disable iff (!rst_n)
        !(own_q[0] && own_q[1]));

    // R9: A takes ownership only while B is already clear.
    p_grab_after_release_r9: assert property (@(posedge clk_a) disable iff (!rst_n)
        $rose(own_q[0]) |-> !own_q[1]);

    // R7: with no owner the output rests at the idle level.
    p_park_level_r7: assert property (@(posedge clk_b) disable iff (!rst_n)
        (own_q == 2'b00) |-> (clk_out == IDLE_HIGH));

    // R2: sole owner A, not cut by bypass, drives the output.
    p_follow_a_r2: assert property (@(posedge clk_b) disable iff (!rst_n)
        (own_q == 2'b01 && !(bypass_a && !(sel_a && en_a))) |-> (clk_out == clk_a));

    // R2: sole owner B, not cut by bypass, drives the output.
    p_follow_b_r2: assert property (@(posedge clk_a) disable iff (!rst_n)
        (own_q == 2'b10 && !(bypass_b && !(sel_b && en_b))) |-> (clk_out == clk_b));

    // R8: no owner means not settled.
    p_parked_not_settled_r8: assert property (@(posedge clk_a) disable iff (!rst_n)
        (own_q == 2'b00) |-> !settled);
endmodule

bind clk_sel2 clk_sel2_chk #(.IDLE_HIGH(IDLE_HIGH)) u_chk (
    .clk_a   (clk_a),
    .clk_b   (clk_b),
    .rst_n   (rst_n),
    .sel_a   (sel_a),
    .en_a    (en_a),
    .sel_b   (sel_b),
    .en_b    (en_b),
    .bypass_a(bypass_a),
    .bypass_b(bypass_b),
    .clk_out (clk_out),
    .settled (settled),
    .own_q   (own_q)
);

// File: tb/clk_sel2_bench.sv
`timescale 1ns/1ps
// Pulse-width and period probe on a selector output.
module clk_sel2_probe #(
    parameter real MIN_NS = 4.9
) (
    input  logic clk_out,
    input  logic armed,
    output int   runt_cnt,
    output int   edge_cnt,
    output int   period_ps
);
    real last_t;
    real last_rise;
    bit  have_last;
    bit  have_rise;

    initial begin
        runt_cnt = 0; edge_cnt = 0; period_ps = 0;
        have_last = 0; have_rise = 0; last_t = 0.0; last_rise = 0.0;
    end

    // Measure every phase width and the rise-to-rise period.
    always @(clk_out) begin
        if (armed && have_last && (($realtime - last_t) < MIN_NS)) runt_cnt = runt_cnt + 1;
        last_t = $realtime;
        have_last = 1;
        if (clk_out === 1'b1) begin
            if (have_rise) period_ps = $rtoi(($realtime - last_rise) * 1000.0 + 0.5);
            last_rise = $realtime;
            have_rise = 1;
            edge_cnt = edge_cnt + 1;
        end
    end
endmodule

module clk_sel2_bench;
    localparam real HALF_A_NS   = 5.0;
    localparam real HALF_B_NS   = 7.0;
    localparam int  PER_A_PS    = 10000;
    localparam int  PER_B_PS    = 14000;
    localparam real WATCHDOG_NS = 1000000.0;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic rst_n = 1'b0;
    logic sel_a = 1'b1, en_a = 1'b1, sel_b = 1'b0, en_b = 1'b1;
    logic bypass_a = 1'b0, bypass_b = 1'b0;
    logic s1_a = 1'b0, s1_b = 1'b1;
    logic clk_out0, settled0, clk_out1, settled1;
    logic armed = 1'b0;
    int   runt0, edges0, per0, runt1, edges1, per1;
    int   checks = 0;
    int   errors = 0;

    always #(HALF_A_NS) clk_a = ~clk_a;
    always #(HALF_B_NS) clk_b = ~clk_b;

    // Default polarity, A preset.
    clk_sel2 u_clk_sel2 (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .sel_a(sel_a), .en_a(en_a), .sel_b(sel_b), .en_b(en_b),
        .bypass_a(bypass_a), .bypass_b(bypass_b),
        .clk_out(clk_out0), .settled(settled0)
    );

    // Idle-high polarity, B preset.
    clk_sel2 #(.IDLE_HIGH(1'b1), .INIT_OWN_A(1'b0), .INIT_OWN_B(1'b1)) u_clk_sel2_hi (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .sel_a(s1_a), .en_a(1'b1), .sel_b(s1_b), .en_b(1'b1),
        .bypass_a(1'b0), .bypass_b(1'b0),
        .clk_out(clk_out1), .settled(settled1)
    );

    clk_sel2_probe u_probe0 (.clk_out(clk_out0), .armed(armed),
        .runt_cnt(runt0), .edge_cnt(edges0), .period_ps(per0));
    clk_sel2_probe u_probe1 (.clk_out(clk_out1), .armed(armed),
        .runt_cnt(runt1), .edge_cnt(edges1), .period_ps(per1));

    // Resulting source: 0 = A, 1 = B, 2 = resting.
    function automatic int next_src(bit sa, bit ea, bit sb, bit eb, int prev);
        bit ra = sa & ea;
        bit rb = sb & eb;
        if (ra && !rb) return 0;
        if (rb && !ra) return 1;
        if (ra && rb)  return prev;
        return 2;
    endfunction

    function automatic int period_of(int src);
        return (src == 0) ? PER_A_PS : PER_B_PS;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $realtime);
        end
    endtask

    // Drive new request lines off any clock edge.
    task automatic drive0(input bit sa, input bit ea, input bit sb, input bit eb);
        @(posedge clk_a);
        #(real'($urandom_range(0, 8)) + 0.3);
        sel_a = sa; en_a = ea; sel_b = sb; en_b = eb;
    endtask

    // Let the switch finish, then check output and status.
    task automatic verify(input int which, input int exp, input string req);
        int e0;
        #200.0;
        e0 = (which == 0) ? edges0 : edges1;
        #120.0;
        if (exp == 2) begin
            if (which == 0) begin
                chk(edges0 == e0, req, edges0 - e0, 0);
                chk(clk_out0 == 1'b0, req, int'(clk_out0), 0);
                chk(settled0 == 1'b0, "R8", int'(settled0), 0);
            end else begin
                chk(edges1 == e0, req, edges1 - e0, 0);
                chk(clk_out1 == 1'b1, req, int'(clk_out1), 1);
                chk(settled1 == 1'b0, "R8", int'(settled1), 0);
            end
        end else begin
            if (which == 0) begin
                chk(per0 == period_of(exp) && edges0 > e0, req, per0, period_of(exp));
                chk(settled0 == 1'b1, "R8", int'(settled0), 1);
            end else begin
                chk(per1 == period_of(exp) && edges1 > e0, req, per1, period_of(exp));
                chk(settled1 == 1'b1, "R8", int'(settled1), 1);
            end
        end
    endtask

    initial begin
        #(WATCHDOG_NS);
        checks++;
        errors++;
        $display("FAIL watchdog R2: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int src;
        void'($urandom(32'd2468));

        // R5: preset owners during reset.
        #100.3;
        chk(settled0 == 1'b1, "R5", int'(settled0), 1);
        chk(settled1 == 1'b1, "R5", int'(settled1), 1);
        rst_n = 1'b1;
        armed = 1'b1;
        #150.0;
        chk(per0 == PER_A_PS, "R5", per0, PER_A_PS);
        chk(per1 == PER_B_PS, "R5", per1, PER_B_PS);
        src = 0;

        // R2: old clock still drives right after the request moves (no bypass).
        @(posedge clk_a);
        #1.3;
        sel_a = 1'b0; sel_b = 1'b1;
        #0.4;
        chk(clk_out0 == 1'b1, "R2", int'(clk_out0), 1);
        verify(0, 1, "R2"); src = 1;

        // R1: select high but enable low is not chosen.
        drive0(1'b0, 1'b1, 1'b1, 1'b0);
        src = next_src(1'b0, 1'b1, 1'b1, 1'b0, src);
        verify(0, src, "R1");
        drive0(1'b1, 1'b0, 1'b1, 1'b0);
        src = next_src(1'b1, 1'b0, 1'b1, 1'b0, src);
        verify(0, src, "R1");

        // R6: both requested keeps the owner.
        drive0(1'b1, 1'b1, 1'b0, 1'b1); src = 0; verify(0, src, "R2");
        drive0(1'b1, 1'b1, 1'b1, 1'b1); verify(0, 0, "R6");
        drive0(1'b0, 1'b1, 1'b1, 1'b1); src = 1; verify(0, src, "R2");
        drive0(1'b1, 1'b1, 1'b1, 1'b1); verify(0, 1, "R6");

        // R7: nothing requested rests the output.
        drive0(1'b0, 1'b1, 1'b0, 1'b1); src = 2; verify(0, src, "R7");
        drive0(1'b1, 1'b1, 1'b1, 1'b1); verify(0, 2, "R6");

        // R4: bypass drops A at once while clk_a is high.
        drive0(1'b1, 1'b1, 1'b0, 1'b1); verify(0, 0, "R2");
        armed = 1'b0;
        bypass_a = 1'b1;
        @(posedge clk_a);
        #1.3;
        sel_a = 1'b0; sel_b = 1'b1;
        #0.4;
        chk(clk_out0 == 1'b0, "R4", int'(clk_out0), 0);
        verify(0, 1, "R4");
        bypass_a = 1'b0;
        armed = 1'b1;
        src = 1;

        // R3: idle-high instance switches and rests high.
        #3.3; s1_a = 1'b1; s1_b = 1'b0;
        verify(1, 0, "R3");
        #3.3; s1_a = 1'b0;
        verify(1, 2, "R3");
        #3.3; s1_b = 1'b1;
        verify(1, 1, "R3");

        // R1 R2 R6 R7: random request patterns.
        for (int n = 0; n < 30; n++) begin
            bit sa = 1'($urandom_range(0, 1));
            bit ea = 1'($urandom_range(0, 1));
            bit sb = 1'($urandom_range(0, 1));
            bit eb = 1'($urandom_range(0, 1));
            drive0(sa, ea, sb, eb);
            src = next_src(sa, ea, sb, eb, src);
            verify(0, src, "R2");
        end

        // R2 R3: no runt phase on either output.
        chk(runt0 == 0, "R2", runt0, 0);
        chk(runt1 == 0, "R3", runt1, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule